// File: doc/BRIEF.md
# Nine-Input Parity Guard for a Word Store

This block protects a small word store with a single parity bit per entry. One combinational parity core looks at nine inputs and yields two complementary results. The odd result is the exclusive-OR of all nine inputs. The even result is formed a different way: the exclusive-OR of the six low inputs is combined with the inverted exclusive-OR of the three high inputs, so it is always the opposite of the odd result.

The same core serves both directions of traffic. On a store, the core sees the eight incoming data bits, with its ninth input held at zero. Its odd result becomes the parity bit kept beside the word. On a fetch, the core sees the eight stored data bits plus the stored parity bit. A high odd result then means the word no longer matches its parity, and the error output is raised.

An inject strobe exclusive-ORs a nine-bit mask into one stored entry. This lets single-bit and double-bit corruption be produced through the ports. The write and read strobes are active high and must not be high in the same cycle. Storage updates are chosen by a small update-kind decode:

- UPD_NONE: nothing changes.
- UPD_WRITE: a write is done; it is taken whenever the write strobe is high.
- UPD_FLIP: the mask is applied; it is taken when the inject strobe is high and the write strobe is low.

Top module: `parity_mem_guard`

## Requirements
- R1: When rd_en is low, the core's inputs are wr_data with the ninth input at 0, so odd_out equals the XOR of the eight wr_data bits.
- R2: even_out is always the complement of odd_out.
- R3: With wr_en high at a rising clock edge, the entry at addr takes data = wr_data and parity bit = XOR of wr_data.
- R4: rd_data and rd_par show the entry selected by addr in the same cycle, with no clock delay.
- R5: With rd_en high, odd_out is the XOR of the stored eight data bits and the stored parity bit, and err equals that value. With rd_en low, err is 0.
- R6: After a single bit of a correctly written entry is flipped (any of data bits 0..7 or the parity bit), a read of that entry raises err.
- R7: After two distinct bits of a correctly written entry are flipped, a read of that entry leaves err at 0.
- R8: With inj_en high and wr_en low at a rising edge, the entry at addr becomes {parity, data} XOR inj_mask. Mask bit 8 hits the parity bit and bits 7..0 hit the data bits. If wr_en is also high, the write takes effect and the mask is ignored.
- R9: While rst_n is low, every entry is cleared to data 0 with parity 0, so a read after reset returns zero with err at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears the store |
| wr_en | input | 1 | Write strobe, active high |
| rd_en | input | 1 | Read strobe, active high |
| inj_en | input | 1 | Corruption strobe, active high |
| addr | input | 4 | Entry index for write, read and inject |
| wr_data | input | 8 | Data to store |
| inj_mask | input | 9 | Bits to flip; bit 8 is the parity bit |
| rd_data | output | 8 | Stored data at addr |
| rd_par | output | 1 | Stored parity bit at addr |
| odd_out | output | 1 | Core odd-parity result |
| even_out | output | 1 | Core even-parity result |
| err | output | 1 | Parity mismatch on read |

## Verification
The read-side outputs (rd_data, rd_par, odd_out, even_out and err) are combinational. They are due in the same cycle their inputs are driven. Writes and injections appear on the read side only after the next rising edge.

The bench drives inputs just after a falling edge and compares every output one nanosecond later, before the rising edge. It updates its own model of the store only after that edge. The bench-side model is a plain array of nine-bit words, and its parity is computed behaviourally.

// File: rtl/pmg_pkg.sv
package pmg_pkg;
    typedef enum logic [1:0] {
        UPD_NONE  = 2'd0,
        UPD_WRITE = 2'd1,
        UPD_FLIP  = 2'd2
    } upd_e;

    function automatic upd_e pick_update(input logic wr, input logic inj);
        upd_e k;
        if (wr)       k = UPD_WRITE;
        else if (inj) k = UPD_FLIP;
        else          k = UPD_NONE;
        return k;
    endfunction
endpackage

// File: rtl/pmg_parity_core.sv
module pmg_parity_core #(
    parameter int N = 9
) (
    input  logic [N-1:0] bits_in,
    output logic         odd_o,
    output logic         even_o
);
    localparam int LOW_N = N - 3;

    logic [N-1:0] chain;

    // running XOR chain for the odd result
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_chain
            if (g == 0) begin : g_first
                assign chain[g] = bits_in[0];
            end else begin : g_next
                assign chain[g] = chain[g-1] ^ bits_in[g];
            end
        end
    endgenerate

    logic low_x, high_x;
    always_comb begin
        low_x  = ^bits_in[LOW_N-1:0];
        high_x = ^bits_in[N-1:LOW_N];
    end

    assign odd_o  = chain[N-1];
    assign even_o = low_x ^ ~high_x;
endmodule

// File: rtl/pmg_store.sv
module pmg_store
    import pmg_pkg::*;
#(
    parameter int W      = 9,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  upd_e              upd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      new_word,
    input  logic [W-1:0]      flip_mask,
    output logic [W-1:0]      cur_word
);
    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else begin
            unique case (upd)
                UPD_WRITE: cells[addr] <= new_word;
                UPD_FLIP:  cells[addr] <= cells[addr] ^ flip_mask;
                default:   ;
            endcase
        end
    end

    assign cur_word = cells[addr];
endmodule

// File: rtl/parity_mem_guard.sv
module parity_mem_guard
    import pmg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              inj_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W:0]   inj_mask,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_par,
    output logic              odd_out,
    output logic              even_out,
    output logic              err
);
    localparam int WORD_W = DATA_W + 1;

    upd_e              upd;
    logic [WORD_W-1:0] stored;
    logic [WORD_W-1:0] core_in;
    logic              core_odd, core_even;

    assign upd = pick_update(wr_en, inj_en);

    // one core, fed from the store on a read and from the write bus otherwise
    always_comb begin
        if (rd_en) core_in = stored;
        else       core_in = {1'b0, wr_data};
    end

    pmg_parity_core #(.N(WORD_W)) core_i (
        .bits_in (core_in),
        .odd_o   (core_odd),
        .even_o  (core_even)
    );

    pmg_store #(.W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (upd),
        .addr      (addr),
        .new_word  ({core_odd, wr_data}),
        .flip_mask (inj_mask),
        .cur_word  (stored)
    );

    assign rd_data  = stored[DATA_W-1:0];
    assign rd_par   = stored[DATA_W];
    assign odd_out  = core_odd;
    assign even_out = core_even;
    assign err      = rd_en & core_odd;
endmodule

// File: rtl/pmg_chk.sv
module pmg_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic              inj_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W:0]   inj_mask,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_par,
    input logic              odd_out,
    input logic              even_out,
    input logic              err
);
    // R1
    idle_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (odd_out == ^wr_data));

    // R2
    even_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        even_out == !odd_out);

    // R3
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (addr != $past(addr)) ||
                  (rd_data == $past(wr_data) && rd_par == ^$past(wr_data)));

    // R5
    err_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (err == (^rd_data ^ rd_par)));

    // R5
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> !err);

    // R8
    flip_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_en && !wr_en) |=> (addr != $past(addr)) ||
            ({rd_par, rd_data} == ($past({rd_par, rd_data}) ^ $past(inj_mask))));
endmodule

bind parity_mem_guard pmg_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .inj_en(inj_en),
    .addr(addr), .wr_data(wr_data), .inj_mask(inj_mask), .rd_data(rd_data),
    .rd_par(rd_par), .odd_out(odd_out), .even_out(even_out), .err(err)
);

// File: tb/parity_mem_guard_tb_top.sv
`timescale 1ns/100ps
module parity_mem_guard_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, inj_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [8:0] inj_mask = '0;
    logic [7:0] rd_data;
    logic       rd_par, odd_out, even_out, err;

    int errors = 0;
    int checks = 0;
    logic [8:0] model [16];

    always #2.5 clk = ~clk;

    parity_mem_guard dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .inj_en(inj_en),
        .addr(addr), .wr_data(wr_data), .inj_mask(inj_mask), .rd_data(rd_data),
        .rd_par(rd_par), .odd_out(odd_out), .even_out(even_out), .err(err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int ones(input logic [8:0] v);
        int n = 0;
        for (int k = 0; k < 9; k++) n += v[k];
        return n;
    endfunction

    // one cycle: drive, compare the combinational outputs, then commit to the model
    task automatic cycle(input logic w, input logic r, input logic j,
                         input logic [3:0] a, input logic [7:0] d,
                         input logic [8:0] m, input string tag);
        logic [8:0] cur;
        logic       exp_odd;
        @(negedge clk);
        wr_en = w; rd_en = r; inj_en = j; addr = a; wr_data = d; inj_mask = m;
        #1;
        cur     = model[a];
        exp_odd = r ? (ones(cur) % 2 == 1) : (ones({1'b0, d}) % 2 == 1);
        chk({tag, " R4 data"}, rd_data, cur[7:0]);
        chk({tag, " R4 par"}, rd_par, cur[8]);
        chk({tag, r ? " R5 odd" : " R1 odd"}, odd_out, exp_odd);
        chk({tag, " R2 even"}, even_out, !exp_odd);
        chk({tag, " R5 err"}, err, r & exp_odd);
        @(posedge clk);
        if (w)      model[a] = {(ones({1'b0, d}) % 2 == 1), d};
        else if (j) model[a] = model[a] ^ m;
    endtask

    task automatic rd_expect(input logic [3:0] a, input logic exp_err, input string tag);
        @(negedge clk);
        wr_en = 0; rd_en = 1; inj_en = 0; addr = a;
        #1;
        chk(tag, err, exp_err);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual=hang expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: cleared store
        for (int i = 0; i < 16; i++) cycle(0, 1, 0, i[3:0], 8'h00, 9'h0, "R9 reset read");

        // R3: varied write patterns, then read back
        cycle(1, 0, 0, 4'd0, 8'h00, 9'h0, "R3 wr");
        cycle(1, 0, 0, 4'd1, 8'hFF, 9'h0, "R3 wr");
        cycle(1, 0, 0, 4'd2, 8'hA5, 9'h0, "R3 wr");
        cycle(1, 0, 0, 4'd3, 8'h01, 9'h0, "R3 wr");
        cycle(1, 0, 0, 4'd4, 8'h80, 9'h0, "R3 wr");
        for (int i = 5; i < 16; i++) cycle(1, 0, 0, i[3:0], 8'(i * 37 + 11), 9'h0, "R3 wr");
        for (int i = 0; i < 16; i++) cycle(0, 1, 0, i[3:0], 8'h5A, 9'h0, "R3 rd");
        rd_expect(4'd3, 1'b0, "R5 clean word no err");

        // R6: every single-bit flip is flagged, then undone
        for (int b = 0; b < 9; b++) begin
            cycle(0, 0, 1, 4'd7, 8'h00, 9'(1 << b), "R8 flip1");
            cycle(0, 1, 0, 4'd7, 8'h00, 9'h0, "R6 rd");
            rd_expect(4'd7, 1'b1, "R6 single flip err");
            cycle(0, 0, 1, 4'd7, 8'h00, 9'(1 << b), "R8 unflip");
            rd_expect(4'd7, 1'b0, "R6 restored no err");
        end

        // R7: double-bit flips are not flagged
        cycle(0, 0, 1, 4'd2, 8'h00, 9'h003, "R8 flip2");
        rd_expect(4'd2, 1'b0, "R7 double flip data");
        cycle(0, 0, 1, 4'd9, 8'h00, 9'h180, "R8 flip2");
        rd_expect(4'd9, 1'b0, "R7 double flip incl parity");
        cycle(0, 1, 0, 4'd9, 8'h00, 9'h0, "R7 rd");

        // R8: write wins over inject in the same cycle
        cycle(1, 0, 1, 4'd5, 8'h3C, 9'h1FF, "R8 wr+inj");
        cycle(0, 1, 0, 4'd5, 8'h00, 9'h0, "R8 rd after wr+inj");

        // R1: idle cycles with varied bus data
        cycle(0, 0, 0, 4'd6, 8'h07, 9'h0, "R1 idle");
        cycle(0, 0, 0, 4'd6, 8'hF0, 9'h0, "R1 idle");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule